// File: doc/BRIEF.md
# Sequencer Start Trigger Generator

This block decides when a downstream timing sequencer may begin a new run, and emits a one-cycle start pulse at that moment. It runs entirely in the slow auxiliary clock domain. A register interface supplies its controls: a two-bit source select, a software request write strobe, a repeat flag, and two three-bit divider factors. The sequencer returns a one-cycle done strobe when its run ends.

Start pulses can come from three places. The first is a programmable divider, whose period is twice the product of two odd factors. The second is a software request bit that has been synchronized to the clock. The third is the immediate restart that repeat mode makes when a run finishes. The software request bit clears itself at the moment its run starts, and its current value is brought out for readback. A halt setting suppresses every source. A run counts as in progress from its start pulse until the done strobe. No new start is issued during that time, and divider events that fall inside it are dropped, not deferred.

Top module: `seq_start_trig`

## Requirements
- R1: After reset, startPulse and swStartBit are 0 and the source select reads halt (00), so no pulse appears until the controls change.
- R2: With trigSel = 00 no start pulse is produced from any source, including repeat mode. A software request written during halt stays pending and produces a pulse on the first edge that samples a software-capable source.
- R3: With trigSel bit 0 set (01 or 11), divider pulses in an idle system are spaced P = (2*facA+1)*(2*facB+1)*2 clock cycles apart, with facA and facB taken as unsigned 3-bit values (P from 2 to 450).
- R4: While trigSel bit 0 is clear, the divider count is held at zero. The first divider pulse rises on the P-th rising edge, counting from and including the first edge that samples a divider-capable source.
- R5: A swStartWr sampled high on edge k (with trigSel bit 1 set and the system idle) yields a start pulse that rises on edge k+2, a latency of 2 cycles, inside the 2.5-cycle bound.
- R6: swStartBit is set by swStartWr and reads 1 until the edge that issues the software-initiated pulse, after which it reads 0. With trigSel = 01 the bit stays set and causes no pulse.
- R7: With trigSel = 11 both the pending software bit and the divider produce pulses, and the divider spacing stays P.
- R8: With repeatEn = 1 and trigSel not 00, a seqDone sampled while a run is in progress gives a start pulse on that same edge, independent of divider and software state.
- R9: Between a start pulse and the edge that samples seqDone, no start pulse is issued. A divider event inside that window is dropped, and the next pulse waits for the following divider event.
- R10: A start pulse is one cycle wide. It is followed by another high cycle only as a repeat restart, when seqDone is sampled together with the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Auxiliary clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigSel | input | 2 | Source select: 00 halt, 01 divider, 10 software, 11 either |
| swStartWr | input | 1 | Write strobe setting the software request bit |
| repeatEn | input | 1 | Restart immediately on seqDone |
| facA | input | 3 | First divider factor field |
| facB | input | 3 | Second divider factor field |
| seqDone | input | 1 | One-cycle end-of-run strobe from the sequencer |
| startPulse | output | 1 | One-cycle start pulse |
| swStartBit | output | 1 | Readback of the self-clearing software request bit |

## Verification
The assertions assume that seqDone arrives only while a run is outstanding, and that the divider factor fields change only while the divider source is deselected. The stimulus keeps to both assumptions. A behavioural sequencer in the bench raises seqDone a chosen number of cycles after each observed pulse, so a done strobe is never spontaneous. Every change to facA and facB is made with trigSel held at halt.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;

  // bit 0 of the select enables the divider, bit 1 the software request
  typedef enum logic [1:0] {
    SRC_HALT = 2'b00,
    SRC_DIV  = 2'b01,
    SRC_SW   = 2'b10,
    SRC_ANY  = 2'b11
  } trigSrcE;

  // strobes from control to datapath
  typedef struct packed {
    logic clrDiv;
    logic clrSwReq;
  } ctlStrobeS;

endpackage

// File: rtl/seq_trig_datapath.sv
module seq_trig_datapath
  import seq_trig_pkg::*;
#(
  parameter int FAC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [FAC_W-1:0] facA,
  input  logic [FAC_W-1:0] facB,
  input  logic             swStartWr,
  input  ctlStrobeS        strobe,
  output logic             divTick,
  output logic             swReady,
  output logic             swBit
);

  localparam int ODD_W  = FAC_W + 1;
  localparam int PROD_W = 2 * ODD_W;
  localparam int PER_W  = PROD_W + 1;

  logic [ODD_W-1:0]  oddA, oddB;
  logic [PROD_W-1:0] oddProd;
  logic [PER_W-1:0]  periodM1;
  logic [PER_W-1:0]  cnt;
  logic              swSync;

  // period = (2A+1)(2B+1)*2, last count value = period - 1
  always_comb begin
    oddA     = {facA, 1'b1};
    oddB     = {facB, 1'b1};
    oddProd  = PROD_W'(oddA) * PROD_W'(oddB);
    periodM1 = {oddProd, 1'b0} - PER_W'(1);
  end

  assign divTick = (cnt >= periodM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.clrDiv)  cnt <= '0;
    else if (divTick)        cnt <= '0;
    else                     cnt <= cnt + PER_W'(1);
  end

  // software request bit and its synchronizing stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swBit  <= 1'b0;
      swSync <= 1'b0;
    end else begin
      if (strobe.clrSwReq)   swBit <= 1'b0;
      else if (swStartWr)    swBit <= 1'b1;
      swSync <= swBit;
    end
  end

  assign swReady = swBit & swSync;

  // R4
  div_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrDiv |=> (cnt == '0));

  // R3
  div_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrDiv && divTick) |=> (cnt == '0));

  // R6
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrSwReq |=> !swBit);

  // R5
  sw_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    !swBit |=> !swReady);

endmodule

// File: rtl/seq_trig_control.sv
module seq_trig_control
  import seq_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] trigSel,
  input  logic       repeatEn,
  input  logic       seqDone,
  input  logic       divTick,
  input  logic       swReady,
  output ctlStrobeS  strobe,
  output logic       startPulse
);

  trigSrcE src;
  logic    useDiv, useSw, active;
  logic    busy;
  logic    repeatFire, divFire, swFire, fire;

  always_comb begin
    src    = trigSrcE'(trigSel);
    useDiv = (src == SRC_DIV) || (src == SRC_ANY);
    useSw  = (src == SRC_SW)  || (src == SRC_ANY);
    active = (src != SRC_HALT);

    repeatFire = active & repeatEn & busy & seqDone;
    divFire    = useDiv & ~busy & divTick;
    swFire     = useSw  & ~busy & swReady;
    fire       = repeatFire | divFire | swFire;

    strobe.clrDiv   = ~useDiv;
    strobe.clrSwReq = swFire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      busy       <= fire | (busy & ~seqDone);
      startPulse <= fire;
    end
  end

  // R2
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigSel == 2'b00) |=> !startPulse);

  // R9
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !seqDone) |=> !startPulse);

  // R8
  repeat_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && seqDone && repeatEn && trigSel != 2'b00) |=> startPulse);

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !(seqDone && repeatEn)) |=> !startPulse);

endmodule

// File: rtl/seq_start_trig.sv
module seq_start_trig
  import seq_trig_pkg::*;
#(
  parameter int FAC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       trigSel,
  input  logic             swStartWr,
  input  logic             repeatEn,
  input  logic [FAC_W-1:0] facA,
  input  logic [FAC_W-1:0] facB,
  input  logic             seqDone,
  output logic             startPulse,
  output logic             swStartBit
);

  ctlStrobeS strobe;
  logic      divTick, swReady;

  seq_trig_datapath #(.FAC_W(FAC_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .facA      (facA),
    .facB      (facB),
    .swStartWr (swStartWr),
    .strobe    (strobe),
    .divTick   (divTick),
    .swReady   (swReady),
    .swBit     (swStartBit)
  );

  seq_trig_control uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .trigSel    (trigSel),
    .repeatEn   (repeatEn),
    .seqDone    (seqDone),
    .divTick    (divTick),
    .swReady    (swReady),
    .strobe     (strobe),
    .startPulse (startPulse)
  );

endmodule

// File: tb/seq_start_trig_test.sv
module seq_start_trig_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] trigSel = 2'b00;
  logic       swStartWr = 1'b0;
  logic       repeatEn = 1'b0;
  logic [2:0] facA = 3'd0;
  logic [2:0] facB = 3'd0;
  logic       seqDone = 1'b0;
  logic       startPulse, swStartBit;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  seq_start_trig uut (
    .clk(clk), .rstN(rstN), .trigSel(trigSel), .swStartWr(swStartWr),
    .repeatEn(repeatEn), .facA(facA), .facB(facB), .seqDone(seqDone),
    .startPulse(startPulse), .swStartBit(swStartBit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural sequencer: done strobe doneDelay cycles after each pulse
  int doneDelay = 1;
  int pending = 0;
  always @(negedge clk) begin
    seqDone = 1'b0;
    if (startPulse) pending = doneDelay;
    if (pending > 0) begin
      pending--;
      if (pending == 0) seqDone = 1'b1;
    end
  end

  // reference model, evaluated on every rising edge
  int  mBit = 0, mAge = 0, mBusy = 0, mCnt = 0, mPulse = 0;
  int  per, rdy, tick, fire, swF, oldBit;
  bit  uDiv, uSw;
  always @(posedge clk) begin
    if (!rstN) begin
      mBit = 0; mAge = 0; mBusy = 0; mCnt = 0; mPulse = 0;
    end else begin
      per  = (2 * int'(facA) + 1) * (2 * int'(facB) + 1) * 2;
      uDiv = trigSel[0];
      uSw  = trigSel[1];
      tick = (uDiv && mCnt >= per - 1) ? 1 : 0;
      rdy  = (mBit != 0 && mAge >= 1) ? 1 : 0;
      swF  = (uSw && mBusy == 0 && rdy != 0) ? 1 : 0;
      fire = 0;
      if (trigSel != 2'b00 && repeatEn && mBusy != 0 && seqDone) fire = 1;
      if (mBusy == 0 && tick != 0) fire = 1;
      if (swF != 0) fire = 1;
      oldBit = mBit;
      if (swF != 0) mBit = 0;
      else if (swStartWr) mBit = 1;
      if (mBit == 0) mAge = 0;
      else if (oldBit != 0) mAge = mAge + 1;
      else mAge = 0;
      mBusy = (fire != 0 || (mBusy != 0 && !seqDone)) ? 1 : 0;
      if (!uDiv) mCnt = 0;
      else if (mCnt >= per - 1) mCnt = 0;
      else mCnt = mCnt + 1;
      mPulse = fire;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(startPulse == mPulse[0], "MODEL", "startPulse", int'(startPulse), mPulse);
      check(swStartBit == mBit[0], "MODEL", "swStartBit", int'(swStartBit), mBit);
    end
  end

  task automatic waitPulse(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!startPulse && n < limit);
    if (!startPulse) n = -1;
  endtask

  task automatic idle(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    int n, seen, per2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(startPulse == 1'b0, "R1", "startPulse after reset", int'(startPulse), 0);
    check(swStartBit == 1'b0, "R1", "swStartBit after reset", int'(swStartBit), 0);
    seen = 0;
    repeat (10) begin @(negedge clk); if (startPulse) seen++; end
    check(seen == 0, "R1", "pulses while in reset-default halt", seen, 0);

    // R3 / R4: sweep every factor pair
    doneDelay = 1;
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        trigSel = 2'b00;
        facA = 3'(a);
        facB = 3'(b);
        @(negedge clk);
        per2 = (2 * a + 1) * (2 * b + 1) * 2;
        trigSel = 2'b01;
        waitPulse(1000, n);
        check(n == per2, "R4", "edges to first divider pulse", n, per2);
        waitPulse(1000, n);
        check(n == per2, "R3", "divider pulse spacing", n, per2);
        @(negedge clk);
        check(startPulse == 1'b0, "R10", "pulse width", int'(startPulse), 0);
      end
    end

    // R2: halt blocks software and repeat, request stays pending
    trigSel = 2'b00;
    repeatEn = 1'b1;
    facA = 3'd0;
    facB = 3'd0;
    @(negedge clk);
    swStartWr = 1'b1;
    @(negedge clk);
    swStartWr = 1'b0;
    seen = 0;
    repeat (30) begin @(negedge clk); if (startPulse) seen++; end
    check(seen == 0, "R2", "pulses in halt", seen, 0);
    check(swStartBit == 1'b1, "R2", "request pending in halt", int'(swStartBit), 1);
    repeatEn = 1'b0;
    trigSel = 2'b10;
    waitPulse(20, n);
    check(n == 1, "R2", "pending request fires on leaving halt", n, 1);
    check(swStartBit == 1'b0, "R6", "bit cleared at its pulse", int'(swStartBit), 0);
    idle(5);

    // R5 / R6: software latency and self-clear
    swStartWr = 1'b1;
    @(negedge clk);
    swStartWr = 1'b0;
    check(swStartBit == 1'b1, "R6", "bit set after write", int'(swStartBit), 1);
    n = 1;
    while (!startPulse && n < 20) begin @(negedge clk); n++; end
    check(n == 3, "R5", "negedges from write to pulse (latency 2)", n, 3);
    check(swStartBit == 1'b0, "R6", "bit cleared with pulse", int'(swStartBit), 0);
    idle(5);

    // R6: divider-only mode ignores the request
    trigSel = 2'b00;
    facA = 3'd7;
    facB = 3'd7;
    @(negedge clk);
    trigSel = 2'b01;
    swStartWr = 1'b1;
    @(negedge clk);
    swStartWr = 1'b0;
    seen = 0;
    repeat (20) begin @(negedge clk); if (startPulse) seen++; end
    check(seen == 0, "R6", "pulses from request in divider mode", seen, 0);
    check(swStartBit == 1'b1, "R6", "request held in divider mode", int'(swStartBit), 1);

    // R7: both sources in mode 11
    trigSel = 2'b11;
    waitPulse(20, n);
    check(n == 1, "R7", "software pulse in either mode", n, 1);
    check(swStartBit == 1'b0, "R7", "bit cleared in either mode", int'(swStartBit), 0);
    waitPulse(1000, n);
    check(n > 0, "R7", "divider pulse arrives in either mode", n, 1);
    waitPulse(1000, n);
    check(n == 450, "R7", "divider spacing in either mode", n, 450);

    // R8: repeat mode restarts on done
    trigSel = 2'b00;
    idle(3);
    doneDelay = 3;
    repeatEn = 1'b1;
    trigSel = 2'b10;
    swStartWr = 1'b1;
    @(negedge clk);
    swStartWr = 1'b0;
    waitPulse(20, n);
    check(n == 2, "R8", "first pulse of repeat run", n, 2);
    waitPulse(20, n);
    check(n == 3, "R8", "repeat restart spacing", n, 3);
    waitPulse(20, n);
    check(n == 3, "R8", "repeat restart spacing again", n, 3);
    trigSel = 2'b00;
    seen = 0;
    repeat (20) begin @(negedge clk); if (startPulse) seen++; end
    check(seen == 0, "R2", "repeat stopped by halt", seen, 0);
    repeatEn = 1'b0;

    // R9: divider event during a run is dropped
    facA = 3'd0;
    facB = 3'd0;
    doneDelay = 4;
    idle(3);
    trigSel = 2'b01;
    waitPulse(20, n);
    check(n == 2, "R9", "first pulse with factor 1", n, 2);
    @(negedge clk);
    check(startPulse == 1'b0, "R10", "pulse width during run", int'(startPulse), 0);
    n = 1;
    while (!startPulse && n < 20) begin @(negedge clk); n++; end
    check(n == 6, "R9", "spacing with dropped divider event", n, 6);
    trigSel = 2'b00;
    idle(10);

    summary();
    $finish;
  end

endmodule